// File: doc/BRIEF.md
# Dual-Port Byte-Lane RAM with Selectable Read Latency

This block is a true dual-port synchronous memory whose words are split into two byte lanes. Two independent ports, A and B, can each read or write any location in the same clock cycle, including the same location. Every control, address and data input of a port passes through a register on the rising clock edge. Reads return data either in the cycle after the access edge (flow-through) or one cycle later (pipelined). Each port makes that choice on its own through a static mode input.

Each port has an active-low and an active-high chip enable, one active-low enable per byte lane, a read/write line and an asynchronous active-low output enable. Read data leaves the block as a data bus plus one drive flag per lane. A cleared flag stands for a high-impedance lane, and the data bits of that lane then read as zero. The chip enables travel through the same number of register stages as the read data, one or two. The lane enables always travel through exactly one. In pipelined mode the lane gating that applies to a returning read therefore comes from the controls presented one cycle after that read.

Inside each port, every captured cycle is classified as one of three access states: ACC_IDLE (port not selected), ACC_READ, or ACC_WRITE. The state advances on every clock. Any state moves to ACC_READ when the port is selected with the read/write line high, to ACC_WRITE when it is selected with the line low, and to ACC_IDLE otherwise. A second copy of the state, one cycle older, feeds the output stage in pipelined mode. Both ports share one clock `clk` and one synchronous active-low reset `rst_n`. The depth is set by `ADDR_W`: `ADDR_W = 13` gives 8K words, and the default is smaller.

Top module: `dp_lane_ram`

## Requirements
- R1: A port is selected only when its `*_sel_n` is 0 and its `*_sel` is 1. A cycle captured with any other combination neither writes the memory nor reads it.
- R2: Lane 1 is word bits 17..9 and lane 0 is bits 8..0. Bit 1 of `*_lane_n` and of `*_rvalid` belong to lane 1, and bit 0 belongs to lane 0.
- R3: A selected cycle with `*_rnw` = 0 writes only the lanes whose `*_lane_n` bit is 0. The other lane of the stored word keeps its previous value.
- R4: A selected cycle with `*_rnw` = 1 reads. Only lanes whose `*_lane_n` bit was 0 at the most recent edge drive, so `*_lane_n` = 2'b11 leaves both lanes undriven.
- R5: While `*_oe_n` is 1, `*_rvalid` is 0 in that same cycle, whatever the registered state is.
- R6: In flow-through mode (`*_pipe` = 0), data read at edge k is on `*_rdata` between edge k and edge k+1.
- R7: In pipelined mode (`*_pipe` = 1), data read at edge k is on `*_rdata` between edge k+1 and edge k+2. This is the value the word held right after edge k.
- R8: In pipelined mode, the chip enables take two register stages. A port deselected at edge k+1 still drives data for its read at edge k, and the output turns off only when the deselect reaches the second stage.
- R9: The lane enables take one register stage in both modes. In pipelined mode, the lanes that drive after edge k+1 are those enabled at edge k+1.
- R10: Both ports may read the same word in the same cycle. A read of a word that the other port writes at the same edge returns the newly written lanes. The result of two writes to the same word at the same edge is undefined.
- R11: `*_pipe` is sampled only while `rst_n` is 0. Changing it after reset has no effect on latency.
- R12: While `rst_n` is 0, and in the first cycle after it, no lane of either port drives. Memory contents are not cleared.
- R13: A write cycle never causes the port to drive its read outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports, rising edge |
| rst_n | input | 1 | Synchronous active-low reset; also latches the mode inputs |
| a_pipe | input | 1 | Port A latency mode: 1 pipelined, 0 flow-through |
| a_sel_n | input | 1 | Port A active-low chip enable |
| a_sel | input | 1 | Port A active-high chip enable |
| a_lane_n | input | LANES | Port A active-low lane enables, bit 1 upper |
| a_rnw | input | 1 | Port A 1 read, 0 write |
| a_oe_n | input | 1 | Port A asynchronous active-low output enable |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | LANES*LANE_W | Port A write data |
| a_rdata | output | LANES*LANE_W | Port A read data, zero in undriven lanes |
| a_rvalid | output | LANES | Port A per-lane drive flags (0 = high-Z) |
| b_pipe | input | 1 | Port B latency mode |
| b_sel_n | input | 1 | Port B active-low chip enable |
| b_sel | input | 1 | Port B active-high chip enable |
| b_lane_n | input | LANES | Port B active-low lane enables |
| b_rnw | input | 1 | Port B 1 read, 0 write |
| b_oe_n | input | 1 | Port B asynchronous active-low output enable |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | LANES*LANE_W | Port B write data |
| b_rdata | output | LANES*LANE_W | Port B read data |
| b_rvalid | output | LANES | Port B per-lane drive flags |

## Verification
A wrong access state shows up on `*_rvalid` within one clock in flow-through mode and within two in pipelined mode. Typical examples are a write taken for a read, or a deselected cycle taken as selected. A missing or extra lane-enable stage shows as the wrong lane driving in the cycle that follows a change of lane enables. A lane written when it should not be stays hidden until that word is read back, so the bench rereads every word through both ports with varied lane patterns.

// File: rtl/dplr_pkg.sv
package dplr_pkg;

    // Kind of access captured by a port at one clock edge.
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_e;

    localparam int NPORT = 2;

endpackage

// File: rtl/dplr_mem.sv
module dplr_mem #(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 9,
    parameter int LANES  = 2,
    parameter int NPORT  = 2
) (
    input  logic                      clk,
    input  logic [LANES-1:0]          we    [NPORT],
    input  logic [ADDR_W-1:0]         waddr [NPORT],
    input  logic [LANES*LANE_W-1:0]   wword [NPORT],
    input  logic [ADDR_W-1:0]         raddr [NPORT],
    output logic [LANES*LANE_W-1:0]   rword [NPORT]
);
    localparam int WORD_W = LANES * LANE_W;
    localparam int DEPTH  = 1 << ADDR_W;

    logic [WORD_W-1:0] store [DEPTH];

    // Single write process: port order decides same-word collisions (R10).
    always_ff @(posedge clk) begin
        for (int p = 0; p < NPORT; p++) begin
            for (int l = 0; l < LANES; l++) begin
                if (we[p][l]) begin
                    store[waddr[p]][l*LANE_W +: LANE_W] <= wword[p][l*LANE_W +: LANE_W];
                end
            end
        end
    end

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_rd
            assign rword[p] = store[raddr[p]];
        end
    endgenerate

endmodule

// File: rtl/dplr_port.sv
module dplr_port
    import dplr_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      pipe_in,
    input  logic                      sel_n,
    input  logic                      sel,
    input  logic [LANES-1:0]          lane_n,
    input  logic                      rnw,
    input  logic                      oe_n,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [LANES*LANE_W-1:0]   wdata,
    output logic [LANES-1:0]          wr_lane,
    output logic [ADDR_W-1:0]         wr_addr,
    output logic [LANES*LANE_W-1:0]   wr_word,
    output logic [ADDR_W-1:0]         rd_addr,
    input  logic [LANES*LANE_W-1:0]   rd_word,
    output logic [LANES*LANE_W-1:0]   rdata,
    output logic [LANES-1:0]          rvalid
);
    localparam int WORD_W = LANES * LANE_W;

    logic               pipe_q;
    acc_e               acc_next, acc_q, acc_qq, acc_eff;
    logic [LANES-1:0]   lane_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [WORD_W-1:0]  hold_q;
    logic [WORD_W-1:0]  word_sel;
    logic [LANES-1:0]   lane_on;

    // Next access state from the chip enables and read/write line (R1).
    always_comb begin
        unique case ({~sel_n & sel, rnw})
            2'b10:   acc_next = ACC_WRITE;
            2'b11:   acc_next = ACC_READ;
            default: acc_next = ACC_IDLE;
        endcase
    end

    // State register: two chip-enable stages, one lane-enable stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= pipe_in;          // R11: mode latched only in reset
            acc_q  <= ACC_IDLE;         // R12
            acc_qq <= ACC_IDLE;
            lane_q <= '1;
            addr_q <= '0;
            hold_q <= '0;
        end else begin
            acc_q  <= acc_next;
            acc_qq <= acc_q;            // R8: second stage
            lane_q <= lane_n;           // R9: single stage
            addr_q <= addr;
            hold_q <= rd_word;          // R7: pipelined data stage
        end
    end

    // Write request goes straight to the array at this edge (R3).
    assign wr_lane = (rst_n && acc_next == ACC_WRITE) ? ~lane_n : '0;
    assign wr_addr = addr;
    assign wr_word = wdata;
    assign rd_addr = addr_q;

    // Output process: lane drive from the effective state and OE (R4, R5).
    always_comb begin
        acc_eff  = pipe_q ? acc_qq : acc_q;
        word_sel = pipe_q ? hold_q : rd_word;
        lane_on  = '0;
        unique case (acc_eff)
            ACC_READ:  lane_on = ~lane_q & {LANES{~oe_n}};
            ACC_WRITE: lane_on = '0;    // R13
            ACC_IDLE:  lane_on = '0;
            default:   lane_on = '0;
        endcase
    end

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            assign rdata[l*LANE_W +: LANE_W] = lane_on[l] ? word_sel[l*LANE_W +: LANE_W] : '0;
        end
    endgenerate
    assign rvalid = lane_on;

endmodule

// File: rtl/dp_lane_ram.sv
module dp_lane_ram
    import dplr_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      a_pipe,
    input  logic                      a_sel_n,
    input  logic                      a_sel,
    input  logic [LANES-1:0]          a_lane_n,
    input  logic                      a_rnw,
    input  logic                      a_oe_n,
    input  logic [ADDR_W-1:0]         a_addr,
    input  logic [LANES*LANE_W-1:0]   a_wdata,
    output logic [LANES*LANE_W-1:0]   a_rdata,
    output logic [LANES-1:0]          a_rvalid,
    input  logic                      b_pipe,
    input  logic                      b_sel_n,
    input  logic                      b_sel,
    input  logic [LANES-1:0]          b_lane_n,
    input  logic                      b_rnw,
    input  logic                      b_oe_n,
    input  logic [ADDR_W-1:0]         b_addr,
    input  logic [LANES*LANE_W-1:0]   b_wdata,
    output logic [LANES*LANE_W-1:0]   b_rdata,
    output logic [LANES-1:0]          b_rvalid
);
    localparam int WORD_W = LANES * LANE_W;

    logic               pp_pipe   [NPORT];
    logic               pp_sel_n  [NPORT];
    logic               pp_sel    [NPORT];
    logic [LANES-1:0]   pp_lane_n [NPORT];
    logic               pp_rnw    [NPORT];
    logic               pp_oe_n   [NPORT];
    logic [ADDR_W-1:0]  pp_addr   [NPORT];
    logic [WORD_W-1:0]  pp_wdata  [NPORT];
    logic [WORD_W-1:0]  pp_rdata  [NPORT];
    logic [LANES-1:0]   pp_rvalid [NPORT];

    logic [LANES-1:0]   m_we    [NPORT];
    logic [ADDR_W-1:0]  m_waddr [NPORT];
    logic [WORD_W-1:0]  m_wword [NPORT];
    logic [ADDR_W-1:0]  m_raddr [NPORT];
    logic [WORD_W-1:0]  m_rword [NPORT];

    assign pp_pipe[0]   = a_pipe;    assign pp_pipe[1]   = b_pipe;
    assign pp_sel_n[0]  = a_sel_n;   assign pp_sel_n[1]  = b_sel_n;
    assign pp_sel[0]    = a_sel;     assign pp_sel[1]    = b_sel;
    assign pp_lane_n[0] = a_lane_n;  assign pp_lane_n[1] = b_lane_n;
    assign pp_rnw[0]    = a_rnw;     assign pp_rnw[1]    = b_rnw;
    assign pp_oe_n[0]   = a_oe_n;    assign pp_oe_n[1]   = b_oe_n;
    assign pp_addr[0]   = a_addr;    assign pp_addr[1]   = b_addr;
    assign pp_wdata[0]  = a_wdata;   assign pp_wdata[1]  = b_wdata;
    assign a_rdata  = pp_rdata[0];   assign b_rdata  = pp_rdata[1];
    assign a_rvalid = pp_rvalid[0];  assign b_rvalid = pp_rvalid[1];

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_port
            dplr_port #(
                .ADDR_W (ADDR_W),
                .LANE_W (LANE_W),
                .LANES  (LANES)
            ) u_port (
                .clk     (clk),
                .rst_n   (rst_n),
                .pipe_in (pp_pipe[p]),
                .sel_n   (pp_sel_n[p]),
                .sel     (pp_sel[p]),
                .lane_n  (pp_lane_n[p]),
                .rnw     (pp_rnw[p]),
                .oe_n    (pp_oe_n[p]),
                .addr    (pp_addr[p]),
                .wdata   (pp_wdata[p]),
                .wr_lane (m_we[p]),
                .wr_addr (m_waddr[p]),
                .wr_word (m_wword[p]),
                .rd_addr (m_raddr[p]),
                .rd_word (m_rword[p]),
                .rdata   (pp_rdata[p]),
                .rvalid  (pp_rvalid[p])
            );
        end
    endgenerate

    dplr_mem #(
        .ADDR_W (ADDR_W),
        .LANE_W (LANE_W),
        .LANES  (LANES),
        .NPORT  (NPORT)
    ) u_mem (
        .clk   (clk),
        .we    (m_we),
        .waddr (m_waddr),
        .wword (m_wword),
        .raddr (m_raddr),
        .rword (m_rword)
    );

endmodule

// File: rtl/dplr_checker.sv
module dplr_checker #(
    parameter int LANES = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             a_sel_n,
    input logic             a_sel,
    input logic [LANES-1:0] a_lane_n,
    input logic             a_rnw,
    input logic             a_oe_n,
    input logic [LANES-1:0] a_rvalid,
    input logic             b_sel_n,
    input logic             b_sel,
    input logic [LANES-1:0] b_lane_n,
    input logic             b_rnw,
    input logic             b_oe_n,
    input logic [LANES-1:0] b_rvalid
);
    logic a_off, b_off, a_wr, b_wr;
    assign a_off = !(!a_sel_n && a_sel);
    assign b_off = !(!b_sel_n && b_sel);
    assign a_wr  = !a_off && !a_rnw;
    assign b_wr  = !b_off && !b_rnw;

    AST_A_OE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        a_oe_n |-> (a_rvalid == '0)); // R5
    AST_B_OE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        b_oe_n |-> (b_rvalid == '0)); // R5
    AST_A_DESEL_TWICE: assert property (@(posedge clk) disable iff (!rst_n)
        (a_off && $past(a_off)) |=> (a_rvalid == '0)); // R1
    AST_B_DESEL_TWICE: assert property (@(posedge clk) disable iff (!rst_n)
        (b_off && $past(b_off)) |=> (b_rvalid == '0)); // R1
    AST_A_NO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (&a_lane_n) |=> (a_rvalid == '0)); // R9
    AST_B_NO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (&b_lane_n) |=> (b_rvalid == '0)); // R9
    AST_A_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (a_wr && $past(a_wr)) |=> (a_rvalid == '0)); // R13
    AST_B_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (b_wr && $past(b_wr)) |=> (b_rvalid == '0)); // R13
    AST_A_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (a_rvalid == '0)); // R12
    AST_B_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (b_rvalid == '0)); // R12

endmodule

bind dp_lane_ram dplr_checker #(.LANES(LANES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .a_sel_n  (a_sel_n),
    .a_sel    (a_sel),
    .a_lane_n (a_lane_n),
    .a_rnw    (a_rnw),
    .a_oe_n   (a_oe_n),
    .a_rvalid (a_rvalid),
    .b_sel_n  (b_sel_n),
    .b_sel    (b_sel),
    .b_lane_n (b_lane_n),
    .b_rnw    (b_rnw),
    .b_oe_n   (b_oe_n),
    .b_rvalid (b_rvalid)
);

// File: tb/dp_lane_ram_test.sv
module dp_lane_ram_test;
    localparam int AW  = 4;
    localparam int LW  = 9;
    localparam int NL  = 2;
    localparam int WW  = NL * LW;
    localparam int DEP = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          p_mode  [2];
    logic          p_sel_n [2];
    logic          p_sel   [2];
    logic [NL-1:0] p_lane_n[2];
    logic          p_rnw   [2];
    logic          p_oe_n  [2];
    logic [AW-1:0] p_addr  [2];
    logic [WW-1:0] p_wdata [2];
    logic [WW-1:0] q_data  [2];
    logic [NL-1:0] q_valid [2];

    dp_lane_ram #(.ADDR_W(AW), .LANE_W(LW), .LANES(NL)) uut (
        .clk(clk), .rst_n(rst_n),
        .a_pipe(p_mode[0]), .a_sel_n(p_sel_n[0]), .a_sel(p_sel[0]), .a_lane_n(p_lane_n[0]),
        .a_rnw(p_rnw[0]), .a_oe_n(p_oe_n[0]), .a_addr(p_addr[0]), .a_wdata(p_wdata[0]),
        .a_rdata(q_data[0]), .a_rvalid(q_valid[0]),
        .b_pipe(p_mode[1]), .b_sel_n(p_sel_n[1]), .b_sel(p_sel[1]), .b_lane_n(p_lane_n[1]),
        .b_rnw(p_rnw[1]), .b_oe_n(p_oe_n[1]), .b_addr(p_addr[1]), .b_wdata(p_wdata[1]),
        .b_rdata(q_data[1]), .b_rvalid(q_valid[1])
    );

    int checks = 0;
    int errors = 0;

    // Requirement-level model
    logic [WW-1:0] m_mem  [DEP];
    bit            m_known[DEP];
    bit            m_pipe [2];
    bit            m_rd1  [2];
    bit            m_rd2  [2];
    logic [NL-1:0] m_lane1[2];
    logic [WW-1:0] m_d1   [2];
    logic [WW-1:0] m_d2   [2];
    bit            m_k1   [2];
    bit            m_k2   [2];
    bit [31:0]     seed   [2];

    task automatic chk(input bit ok, input string tag, input int p, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s port %0d %s got %h expected %h", tag, p, what, act, exp);
        end
    endtask

    function automatic bit [31:0] xs(input bit [31:0] x);
        bit [31:0] y = x;
        y ^= y << 13;
        y ^= y >> 17;
        y ^= y << 5;
        return y;
    endfunction

    task automatic set_idle(input int p);
        p_sel_n[p] = 1'b1; p_sel[p] = 1'b1; p_lane_n[p] = 2'b00;
        p_rnw[p] = 1'b1;   p_oe_n[p] = 1'b0; p_addr[p] = '0; p_wdata[p] = '0;
    endtask

    task automatic set_op(input int p, input bit rnw, input logic [AW-1:0] a,
                          input logic [WW-1:0] d, input logic [NL-1:0] ln, input bit oe_n);
        p_sel_n[p] = 1'b0; p_sel[p] = 1'b1; p_rnw[p] = rnw; p_addr[p] = a;
        p_wdata[p] = d;    p_lane_n[p] = ln; p_oe_n[p] = oe_n;
    endtask

    // Apply the upcoming edge to the model (R3, R10).
    task automatic model_edge();
        bit wr [2];
        for (int p = 0; p < 2; p++)
            wr[p] = !p_sel_n[p] && p_sel[p] && !p_rnw[p] && (p_lane_n[p] != 2'b11);
        if (wr[0] && wr[1] && p_addr[0] == p_addr[1]) begin
            m_known[p_addr[0]] = 1'b0;
        end else begin
            for (int p = 0; p < 2; p++) begin
                if (wr[p]) begin
                    for (int l = 0; l < NL; l++)
                        if (!p_lane_n[p][l])
                            m_mem[p_addr[p]][l*LW +: LW] = p_wdata[p][l*LW +: LW];
                    if (p_lane_n[p] == 2'b00) m_known[p_addr[p]] = 1'b1;
                end
            end
        end
        for (int p = 0; p < 2; p++) begin
            m_rd2[p]   = m_rd1[p];
            m_d2[p]    = m_d1[p];
            m_k2[p]    = m_k1[p];
            m_rd1[p]   = !p_sel_n[p] && p_sel[p] && p_rnw[p];
            m_lane1[p] = p_lane_n[p];
            m_d1[p]    = m_mem[p_addr[p]];
            m_k1[p]    = m_known[p_addr[p]];
        end
    endtask

    task automatic check_ports(input string tag);
        for (int p = 0; p < 2; p++) begin
            bit            rd  = m_pipe[p] ? m_rd2[p] : m_rd1[p];
            bit            kn  = m_pipe[p] ? m_k2[p]  : m_k1[p];
            logic [WW-1:0] dd  = m_pipe[p] ? m_d2[p]  : m_d1[p];
            logic [NL-1:0] ev  = (rd && !p_oe_n[p]) ? ~m_lane1[p] : 2'b00;
            string tv = (tag != "") ? tag : (p_oe_n[p] ? "R5" : (m_pipe[p] ? "R8" : "R1"));
            string td = (tag != "") ? tag : (m_pipe[p] ? "R7" : "R6");
            chk(q_valid[p] == ev, tv, p, "rvalid", 32'(q_valid[p]), 32'(ev));
            for (int l = 0; l < NL; l++)
                if (ev[l] && kn)
                    chk(q_data[p][l*LW +: LW] == dd[l*LW +: LW], td, p, "lane data",
                        32'(q_data[p][l*LW +: LW]), 32'(dd[l*LW +: LW]));
        end
    endtask

    task automatic step(input string tag);
        model_edge();
        @(negedge clk);
        check_ports(tag);
    endtask

    task automatic do_reset(input bit ma, input bit mb);
        rst_n = 1'b0;
        set_idle(0); set_idle(1);
        p_mode[0] = ma; p_mode[1] = mb;
        repeat (3) @(negedge clk);
        for (int p = 0; p < 2; p++) begin
            chk(q_valid[p] == 2'b00, "R12", p, "rvalid in reset", 32'(q_valid[p]), 0);
            m_pipe[p] = p_mode[p]; m_rd1[p] = 0; m_rd2[p] = 0; m_lane1[p] = 2'b11;
        end
        rst_n = 1'b1;
    endtask

    task automatic rand_op(input int p);
        bit [31:0] r;
        seed[p] = xs(seed[p]);
        r = seed[p];
        p_sel_n[p]  = r[0] & r[1];
        p_sel[p]    = !(r[2] & r[3]);
        p_lane_n[p] = r[5:4];
        p_rnw[p]    = r[6] | r[7];
        p_oe_n[p]   = r[8] & r[9];
        p_addr[p]   = r[13:10];
        p_wdata[p]  = r[31:14];
        p_mode[p]   = r[20];          // R11: ignored after reset
    endtask

    initial begin
        for (int i = 0; i < DEP; i++) m_known[i] = 1'b0;
        seed[0] = 32'h1234_5678; seed[1] = 32'h9E37_79B9;
        set_idle(0); set_idle(1);
        p_mode[0] = 1'b0; p_mode[1] = 1'b0;

        for (int combo = 0; combo < 4; combo++) begin
            do_reset(combo[0], combo[1]);
            for (int a = 0; a < DEP; a++) begin
                set_op(0, 1'b0, AW'(a), WW'(a * 18'h04C1D + 18'h01234), 2'b00, 1'b0);
                set_idle(1);
                step("");
            end
            for (int n = 0; n < 1500; n++) begin
                rand_op(0); rand_op(1);
                step("");
            end
        end

        // Directed: A flow-through, B pipelined
        do_reset(1'b0, 1'b1);
        set_op(0, 1'b0, 4'd2, 18'h155AA, 2'b00, 1'b1); set_idle(1); step("R3");
        set_op(0, 1'b0, 4'd2, 18'h3FFFF, 2'b01, 1'b1); step("R3");
        set_op(0, 1'b1, 4'd2, 18'h0, 2'b00, 1'b0); step("R3");
        chk(q_data[0] == 18'h3FFAA && q_valid[0] == 2'b11, "R3", 0, "merged word",
            32'(q_data[0]), 32'h3FFAA);
        set_op(0, 1'b1, 4'd2, 18'h0, 2'b01, 1'b0); step("R2");
        chk(q_valid[0] == 2'b10 && q_data[0][17:9] == 9'h1FF && q_data[0][8:0] == 9'h0,
            "R2", 0, "upper lane only", 32'(q_data[0]), 32'h3FE00);
        set_op(0, 1'b1, 4'd2, 18'h0, 2'b11, 1'b0); step("R4");
        chk(q_valid[0] == 2'b00, "R4", 0, "no lanes", 32'(q_valid[0]), 0);
        set_op(0, 1'b1, 4'd2, 18'h0, 2'b00, 1'b1); step("R5");
        set_op(0, 1'b1, 4'd2, 18'h0, 2'b00, 1'b0); p_sel[0] = 1'b0; step("R1");
        set_op(0, 1'b0, 4'd9, 18'h00F0F, 2'b00, 1'b0); step("R13");
        chk(q_valid[0] == 2'b00, "R13", 0, "write drives", 32'(q_valid[0]), 0);
        set_op(0, 1'b1, 4'd2, 18'h0, 2'b00, 1'b0); step("R6");
        chk(q_data[0] == 18'h3FFAA, "R6", 0, "flow-through data", 32'(q_data[0]), 32'h3FFAA);

        set_idle(0);
        set_op(1, 1'b1, 4'd2, 18'h0, 2'b00, 1'b0); step("R7");
        chk(q_valid[1] == 2'b00, "R7", 1, "early drive", 32'(q_valid[1]), 0);
        set_idle(1); step("R8");
        chk(q_valid[1] == 2'b11 && q_data[1] == 18'h3FFAA, "R8", 1, "drive after deselect",
            32'(q_data[1]), 32'h3FFAA);
        step("R8");
        chk(q_valid[1] == 2'b00, "R8", 1, "second deselect", 32'(q_valid[1]), 0);
        set_op(1, 1'b1, 4'd2, 18'h0, 2'b00, 1'b0); step("R9");
        set_op(1, 1'b1, 4'd2, 18'h0, 2'b10, 1'b0); step("R9");
        chk(q_valid[1] == 2'b01 && q_data[1] == 18'h001AA, "R9", 1, "late lane gate",
            32'(q_data[1]), 32'h001AA);

        set_op(0, 1'b0, 4'd7, 18'h2D2D2, 2'b00, 1'b0);
        set_op(1, 1'b1, 4'd7, 18'h0, 2'b00, 1'b0); step("R10");
        set_idle(0); set_idle(1); step("R10");
        chk(q_data[1] == 18'h2D2D2 && q_valid[1] == 2'b11, "R10", 1, "read during write",
            32'(q_data[1]), 32'h2D2D2);
        set_op(0, 1'b1, 4'd7, 18'h0, 2'b00, 1'b0);
        set_op(1, 1'b1, 4'd7, 18'h0, 2'b00, 1'b0); step("R10");
        chk(q_data[0] == 18'h2D2D2, "R10", 0, "shared read", 32'(q_data[0]), 32'h2D2D2);
        set_idle(0); set_idle(1); step("R10");
        chk(q_data[1] == 18'h2D2D2, "R10", 1, "shared read", 32'(q_data[1]), 32'h2D2D2);

        p_mode[0] = 1'b1; p_mode[1] = 1'b0;
        set_op(0, 1'b1, 4'd2, 18'h0, 2'b00, 1'b0); set_idle(1); step("R11");
        chk(q_valid[0] == 2'b11 && q_data[0] == 18'h3FFAA, "R11", 0, "mode held",
            32'(q_data[0]), 32'h3FFAA);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule